// File: doc/BRIEF.md
# Frame-Synchronous Command Sequencer

This block holds register-write commands that software queues ahead of time and releases each one when the sensor frame it is tagged for begins. Every command carries a relative frame offset, a register address and a data word. The offset says how many frame starts in the future the write must land. A frame-start pulse from the sensor channel moves the current-frame number forward. The sequencer then drains the commands for that frame onto a plain register-write output with a valid/ready handshake.

Each sensor channel gets its own instance, driven by that channel's frame starts. Storage is a ring of sixteen per-frame queues, indexed by absolute frame number modulo sixteen. This lets a command be scheduled up to fourteen frames ahead. Writes that cannot be accepted are reported through a sticky error flag for bad offsets and a drop counter for full queues.

Top module: `frame_cmd_seq`

## Requirements
- R1: A command written with offset k (1 to 14) is not presented on the output until k frame-start pulses have been received after the write.
- R2: The target frame is the current-frame number in the cycle of the write plus the offset, modulo 16. A write in the same cycle as a frame-start pulse uses the number from before that pulse.
- R3: A write with offset 15 is discarded and sets `bad_offset_err`, which stays at 1 until reset.
- R4: A command written with offset 0 is presented on the output in the cycle after the write, provided no earlier command is still waiting.
- R5: Commands that target the same frame leave in the order they were written.
- R6: While `cmd_valid` is 1 and `cmd_ready` is 0, `cmd_valid`, `cmd_addr` and `cmd_data` hold their values. While `cmd_ready` is 1, one command leaves per clock.
- R7: Each per-frame queue holds DEPTH commands (default 4). A write to a full queue is dropped and increments `drop_count`, which saturates at its maximum. The commands already queued are unaffected.
- R8: Commands still waiting for an earlier frame when a frame-start pulse arrives are issued before any command of the new frame.
- R9: Each frame-start pulse increments `cur_frame` by one, modulo 16.
- R10: After reset, `cmd_valid` is 0, `bad_offset_err` is 0, `drop_count` is 0 and `cur_frame` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| frame_start | input | 1 | One-cycle pulse at the start of each sensor frame |
| wr_valid | input | 1 | Command write strobe from software |
| wr_offset | input | 4 | Frames ahead of the current frame (0 to 14 accepted) |
| wr_addr | input | 16 | Target register address of the command |
| wr_data | input | 32 | Data word of the command |
| cmd_valid | output | 1 | A command is presented on the output |
| cmd_ready | input | 1 | Downstream accepts the presented command |
| cmd_addr | output | 16 | Address of the presented command |
| cmd_data | output | 32 | Data of the presented command |
| cur_frame | output | 4 | Current frame number, modulo 16 |
| bad_offset_err | output | 1 | Sticky flag for a write with offset 15 |
| drop_count | output | 8 | Saturating count of writes dropped at a full queue |

## Verification
A frame pointer or slot index that is off by one shows up at the ports within a couple of clocks. Commands then leave one frame early or late, or a command of offset zero fails to appear in the cycle after its write. A queue pointer that is wrong corrupts the order or the content of the next burst. It also breaks the one-per-clock spacing, which the handshake test sees on the first drained frame. Wrong full detection shows up as a drop count that differs from the number of excess writes. It is also visible as more or fewer than DEPTH commands released at the next frame start.

// File: rtl/fcs_pkg.sv
// Shared widths and the command record of the frame command sequencer.
// Assumes every instance in the chip uses the same bus widths.
package fcs_pkg;
    localparam int ADDR_W = 16;
    localparam int DATA_W = 32;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } cmd_t;
endpackage

// File: rtl/fcs_admit.sv
// Admission stage: turns a relative frame offset into an absolute queue
// slot and decides whether the write is stored. The highest offset is
// reserved, because it would alias the slot of the frame before the current
// one. Assumes the queue full flags are current in the cycle of the write.
module fcs_admit #(
    parameter int SLOT_W = 4,
    parameter int DROP_W = 8,
    localparam int SLOTS = 1 << SLOT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [SLOT_W-1:0] wr_offset,
    input  logic [SLOT_W-1:0] cur_frame,
    input  logic [SLOTS-1:0]  full,
    output logic              push,
    output logic [SLOT_W-1:0] push_slot,
    output logic              err_flag,
    output logic [DROP_W-1:0] drop_count
);
    localparam logic [SLOT_W-1:0] RESERVED = SLOT_W'(SLOTS - 1);

    logic reserved_hit;
    logic full_hit;

    // Absolute slot of the written command and its acceptance decision.
    always_comb begin
        push_slot    = cur_frame + wr_offset;
        reserved_hit = wr_valid && (wr_offset == RESERVED);
        full_hit     = wr_valid && !reserved_hit && full[push_slot];
        push         = wr_valid && !reserved_hit && !full[push_slot];
    end

    // Sticky flag for writes that use the reserved offset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_flag <= 1'b0;
        else if (reserved_hit)
            err_flag <= 1'b1;
    end

    // Saturating count of writes lost to a full queue.
    always_ff @(posedge clk) begin
        if (!rst_n)
            drop_count <= '0;
        else if (full_hit && (drop_count != {DROP_W{1'b1}}))
            drop_count <= drop_count + DROP_W'(1);
    end

    a_r3_reserved_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_offset == RESERVED) |=> err_flag);

    a_r7_drop_counted: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_offset != RESERVED && full[cur_frame + wr_offset]
         && drop_count != {DROP_W{1'b1}})
        |=> drop_count == $past(drop_count) + DROP_W'(1));
endmodule

// File: rtl/fcs_slot_queues.sv
// Ring of per-frame FIFO queues, one per absolute frame number modulo the
// slot count. One push and one pop per cycle, possibly to the same slot.
// Assumes the caller never pushes to a full slot or pops an empty one.
module fcs_slot_queues
    import fcs_pkg::*;
#(
    parameter int SLOT_W = 4,
    parameter int DEPTH  = 4,
    localparam int SLOTS = 1 << SLOT_W,
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [SLOT_W-1:0] push_slot,
    input  cmd_t              push_cmd,
    input  logic              pop,
    input  logic [SLOT_W-1:0] pop_slot,
    output logic [SLOTS-1:0]  full,
    output logic [SLOTS-1:0]  empty,
    output cmd_t              head
);
    cmd_t heads [SLOTS];

    assign head = heads[pop_slot];

    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        logic [IDX_W-1:0] wi;
        logic [IDX_W-1:0] ri;
        logic [CNT_W-1:0] cnt;
        cmd_t             mem [DEPTH];
        logic             do_push;
        logic             do_pop;

        assign do_push  = push && (push_slot == SLOT_W'(s));
        assign do_pop   = pop && (pop_slot == SLOT_W'(s));
        assign full[s]  = (cnt == CNT_W'(DEPTH));
        assign empty[s] = (cnt == '0);
        assign heads[s] = mem[ri];

        // Read and write indices and occupancy of this slot.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                wi  <= '0;
                ri  <= '0;
                cnt <= '0;
            end else begin
                if (do_push)
                    wi <= (wi == IDX_W'(DEPTH - 1)) ? '0 : wi + IDX_W'(1);
                if (do_pop)
                    ri <= (ri == IDX_W'(DEPTH - 1)) ? '0 : ri + IDX_W'(1);
                cnt <= cnt + CNT_W'(do_push) - CNT_W'(do_pop);
            end
        end

        // Command storage; contents need no reset.
        always_ff @(posedge clk) begin
            if (do_push)
                mem[wi] <= push_cmd;
        end

        a_r7_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
            do_push |-> (cnt != CNT_W'(DEPTH)));

        a_r6_no_pop_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
            do_pop |-> (cnt != '0));
    end
endmodule

// File: rtl/fcs_issue.sv
// Issue control: keeps the current-frame number and an issue pointer that
// trails it. The pointer drains an earlier frame's queue completely before
// it moves on, so leftovers go out first. Assumes frame starts are spaced
// so that the pointer lags the current frame by no more than one or two
// slots.
module fcs_issue #(
    parameter int SLOT_W = 4,
    localparam int SLOTS = 1 << SLOT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic [SLOTS-1:0]  empty,
    input  logic              out_ready,
    output logic [SLOT_W-1:0] cur_frame,
    output logic [SLOT_W-1:0] iss_slot,
    output logic              out_valid,
    output logic              pop
);
    // Output handshake from the queue under the issue pointer.
    always_comb begin
        out_valid = !empty[iss_slot];
        pop       = out_valid && out_ready;
    end

    // Frame counter and issue pointer advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_frame <= '0;
            iss_slot  <= '0;
        end else begin
            if (frame_start)
                cur_frame <= cur_frame + SLOT_W'(1);
            if ((iss_slot != cur_frame) && empty[iss_slot])
                iss_slot <= iss_slot + SLOT_W'(1);
        end
    end

    a_r9_frame_step: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> cur_frame == $past(cur_frame) + SLOT_W'(1));

    a_r8_drain_before_move: assert property (@(posedge clk) disable iff (!rst_n)
        ((iss_slot != cur_frame) && !empty[iss_slot] && !pop) |=> iss_slot == $past(iss_slot));
endmodule

// File: rtl/frame_cmd_seq.sv
// Frame-synchronous command sequencer for one sensor channel. Software
// queues register writes against future frames. Each frame start releases
// the writes of the new frame onto a valid/ready register-write output.
// Assumes frame_start is a single-cycle pulse in the clk domain.
module frame_cmd_seq
    import fcs_pkg::*;
#(
    parameter int SLOT_W = 4,
    parameter int DEPTH  = 4,
    parameter int DROP_W = 8,
    localparam int SLOTS = 1 << SLOT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              wr_valid,
    input  logic [SLOT_W-1:0] wr_offset,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              cmd_valid,
    input  logic              cmd_ready,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_data,
    output logic [SLOT_W-1:0] cur_frame,
    output logic              bad_offset_err,
    output logic [DROP_W-1:0] drop_count
);
    logic [SLOTS-1:0]  full;
    logic [SLOTS-1:0]  empty;
    logic              push;
    logic [SLOT_W-1:0] push_slot;
    logic              pop;
    logic [SLOT_W-1:0] iss_slot;
    cmd_t              wr_cmd;
    cmd_t              head;

    // Pack the incoming command and unpack the presented one.
    always_comb begin
        wr_cmd.addr = wr_addr;
        wr_cmd.data = wr_data;
        cmd_addr    = head.addr;
        cmd_data    = head.data;
    end

    fcs_admit #(.SLOT_W(SLOT_W), .DROP_W(DROP_W)) u_admit (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_valid   (wr_valid),
        .wr_offset  (wr_offset),
        .cur_frame  (cur_frame),
        .full       (full),
        .push       (push),
        .push_slot  (push_slot),
        .err_flag   (bad_offset_err),
        .drop_count (drop_count)
    );

    fcs_slot_queues #(.SLOT_W(SLOT_W), .DEPTH(DEPTH)) u_queues (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_slot (push_slot),
        .push_cmd  (wr_cmd),
        .pop       (pop),
        .pop_slot  (iss_slot),
        .full      (full),
        .empty     (empty),
        .head      (head)
    );

    fcs_issue #(.SLOT_W(SLOT_W)) u_issue (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .empty       (empty),
        .out_ready   (cmd_ready),
        .cur_frame   (cur_frame),
        .iss_slot    (iss_slot),
        .out_valid   (cmd_valid),
        .pop         (pop)
    );

    a_r6_hold_while_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_addr) && $stable(cmd_data)));

    a_r3_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        bad_offset_err |=> bad_offset_err);
endmodule

// File: tb/frame_cmd_seq_test.sv
module frame_cmd_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_start = 1'b0;
    logic        wr_valid = 1'b0;
    logic [3:0]  wr_offset = '0;
    logic [15:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        cmd_ready = 1'b1;
    logic        cmd_valid;
    logic [15:0] cmd_addr;
    logic [31:0] cmd_data;
    logic [3:0]  cur_frame;
    logic        bad_offset_err;
    logic [7:0]  drop_count;

    int nchecks = 0;
    int nerr = 0;
    int cyc = 0;
    int nlog = 0;
    int base;
    logic [3:0]  exp_cur = '0;
    logic [15:0] log_addr [64];
    logic [31:0] log_data [64];
    int          log_cyc  [64];

    // Vector table: offset and expected position in the output stream.
    localparam logic [3:0] T_OFF [8] = '{4'd1, 4'd0, 4'd3, 4'd1, 4'd14, 4'd0, 4'd3, 4'd2};
    localparam int         T_POS [8] = '{2, 0, 5, 3, 7, 1, 6, 4};

    frame_cmd_seq uut (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .wr_valid(wr_valid), .wr_offset(wr_offset), .wr_addr(wr_addr), .wr_data(wr_data),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
        .cur_frame(cur_frame), .bad_offset_err(bad_offset_err), .drop_count(drop_count)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Record every completed handshake (inputs only change just after posedge).
    always @(negedge clk) begin
        if (rst_n && cmd_valid && cmd_ready && nlog < 64) begin
            log_addr[nlog] = cmd_addr;
            log_data[nlog] = cmd_data;
            log_cyc[nlog]  = cyc;
            nlog++;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        nchecks++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] off, input logic [15:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        wr_valid = 1'b1; wr_offset = off; wr_addr = a; wr_data = d;
        @(posedge clk); #1;
        wr_valid = 1'b0;
    endtask

    task automatic frame(input int gap);
        @(posedge clk); #1;
        frame_start = 1'b1;
        @(posedge clk); #1;
        frame_start = 1'b0;
        exp_cur = exp_cur + 4'd1;
        repeat (gap) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10 valid", cmd_valid, 0);
        chk("R10 err", bad_offset_err, 0);
        chk("R10 drops", drop_count, 0);
        chk("R10 frame", cur_frame, 0);

        // Table walk: R1 R2 R5 ordering across frames
        for (int i = 0; i < 8; i++)
            wr(T_OFF[i], 16'h0100 + 16'(i), 32'hD000_0000 + 32'(i * 17));
        repeat (3) @(negedge clk);
        chk("R4 offset0 issued", nlog, 2);
        frame(10); chk("R1 after frame1", nlog, 4);
        frame(10); chk("R1 after frame2", nlog, 5);
        frame(10); chk("R1 after frame3", nlog, 7);
        for (int f = 4; f <= 13; f++) frame(4);
        chk("R1 not early offset14", nlog, 7);
        frame(10); chk("R1 offset14 released", nlog, 8);
        for (int i = 0; i < 8; i++) begin
            chk("R5 table addr", log_addr[T_POS[i]], 16'h0100 + 16'(i));
            chk("R5 table data", log_data[T_POS[i]], 32'hD000_0000 + 32'(i * 17));
        end
        chk("R9 frame count", cur_frame, exp_cur);

        // R4 and R6: offset 0 appears next cycle and holds while stalled
        cmd_ready = 1'b0;
        base = nlog;
        wr(4'd0, 16'h0A0A, 32'h1234_5678);
        @(negedge clk);
        chk("R4 next cycle valid", cmd_valid, 1);
        repeat (3) @(negedge clk);
        chk("R6 held valid", cmd_valid, 1);
        chk("R6 held addr", cmd_addr, 16'h0A0A);
        chk("R6 held data", cmd_data, 32'h1234_5678);
        chk("R6 no transfer while stalled", nlog, base);
        @(posedge clk); #1 cmd_ready = 1'b1;
        repeat (3) @(negedge clk);
        chk("R6 transferred", nlog, base + 1);

        // R8: leftovers of an earlier frame first
        cmd_ready = 1'b0;
        base = nlog;
        wr(4'd0, 16'h0B01, 32'hB1);
        wr(4'd0, 16'h0B02, 32'hB2);
        wr(4'd1, 16'h0B03, 32'hB3);
        frame(1);
        wr(4'd0, 16'h0B04, 32'hB4);
        @(posedge clk); #1 cmd_ready = 1'b1;
        repeat (10) @(negedge clk);
        chk("R8 count", nlog, base + 4);
        for (int k = 0; k < 4; k++)
            chk("R8 order", log_addr[base + k], 16'h0B01 + 16'(k));

        // R7: overflow of one frame queue, then one-per-clock drain (R6)
        base = nlog;
        for (int k = 0; k < 6; k++)
            wr(4'd1, 16'h0C00 + 16'(k), 32'hC0 + 32'(k));
        @(negedge clk);
        chk("R7 drop count", drop_count, 2);
        frame(10);
        chk("R7 kept count", nlog, base + 4);
        for (int k = 0; k < 4; k++)
            chk("R7 kept order", log_addr[base + k], 16'h0C00 + 16'(k));
        for (int k = 1; k < 4; k++)
            chk("R6 one per clock", log_cyc[base + k] - log_cyc[base + k - 1], 1);

        // R3: reserved offset rejected and never issued
        base = nlog;
        wr(4'd15, 16'h0E0E, 32'hEE);
        @(negedge clk);
        chk("R3 flag set", bad_offset_err, 1);
        for (int f = 0; f < 16; f++) frame(3);
        chk("R3 never issued", nlog, base);
        chk("R3 flag sticky", bad_offset_err, 1);
        chk("R9 wrap", cur_frame, exp_cur);

        // R2: write in the same cycle as frame start uses the old number
        base = nlog;
        @(posedge clk); #1;
        frame_start = 1'b1; wr_valid = 1'b1; wr_offset = 4'd1;
        wr_addr = 16'h0F0F; wr_data = 32'hF0;
        @(posedge clk); #1;
        frame_start = 1'b0; wr_valid = 1'b0;
        exp_cur = exp_cur + 4'd1;
        repeat (5) @(negedge clk);
        chk("R2 same-cycle write issued", nlog, base + 1);
        chk("R2 same-cycle addr", log_addr[base], 16'h0F0F);
        chk("R9 final frame", cur_frame, exp_cur);

        $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
        $finish;
    end
endmodule